// File: doc/BRIEF.md
# Early Branch Resolution and Static Prediction Unit

This unit handles conditional branches for a five-stage in-order pipeline. It settles each branch in the decode stage (ID) rather than in the memory stage. A branch tests one source register against zero, either for equality or for inequality. A dedicated adder, separate from the ALU, forms both candidate next PCs in the same cycle. A wrong guess therefore costs a single fetch slot instead of three.

A predecode hint from the fetch stage (IF) says whether the word being fetched is a conditional branch. The hint comes with that word's sign-extended offset. A static policy then picks the next fetch address. The policy can be always not-taken, always taken, or direction-based, where a backward offset is predicted taken and a forward offset is predicted not taken. The guess is recorded with the fetched word. One cycle later, when that word sits in ID, the unit compares the recorded guess with the real outcome. On a mismatch it redirects fetch to the correct address and flushes the wrongly fetched word in IF/ID by clearing that register's valid bit.

All pins are plain, single-cycle control and address signals. There is no stream interface and no back-pressure: the pipeline advances every cycle, and the unit's outputs are combinational from its inputs and one internal register. `next_pc` is the address the fetch stage must use at the next clock edge. `flush_ifid` tells the IF/ID register to load an invalid slot at that same edge.

Top module: `early_branch_unit`

## Requirements
- R1: Both adders produce a sequential address of PC + 4 and a target of PC + 4 + offset, modulo 2^XLEN, so an address near the top of the space wraps through zero.
- R2: The branch kind is encoded as 2'b01 = branch if the operand is zero, 2'b10 = branch if the operand is non-zero. `br_taken` is high in a cycle only when `id_valid` is high, the ID kind is 01 or 10, and its zero test passes.
- R3: Under policy 2'b00, or the spare code 2'b11, a fetched branch is predicted not taken, and `next_pc` is the IF PC + 4.
- R4: Under policy 2'b01, a fetched branch (`if_valid` and `if_is_br` high) is predicted taken, and `next_pc` is the IF target.
- R5: Under policy 2'b10, a fetched branch whose offset bit XLEN-1 is set (a backward branch) is predicted taken. A branch with that bit clear is predicted not taken.
- R6: The guess made for a fetched branch is stored at the clock edge. In the next cycle `mispredict` is high exactly when a valid branch in ID has an outcome different from that stored guess.
- R7: During a mispredict, `flush_ifid` is high in the same cycle. `next_pc` is the ID target if the branch is taken, or the ID PC + 4 if it is not, and this overrides any IF-side choice. The pulse lasts one cycle: the one-cycle penalty.
- R8: When a branch in ID matches its guess, `flush_ifid` stays low and `next_pc` follows the IF-side choice.
- R9: When `id_valid` is low or the ID kind is 2'b00 or 2'b11, `flush_ifid`, `mispredict` and `br_taken` stay low, even if the previous fetch carried a taken guess.
- R10: While `rst_n` is low the stored guess is cleared. The first branch seen in ID after reset is therefore compared against a not-taken guess.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy | input | 2 | Static policy: 00 not-taken, 01 taken, 10 by direction, 11 as 00 |
| if_valid | input | 1 | IF holds a real fetch |
| if_pc | input | XLEN | PC of the word in IF |
| if_is_br | input | 1 | Predecode: the IF word is a conditional branch |
| if_imm | input | XLEN | Sign-extended offset of the IF word |
| id_valid | input | 1 | IF/ID holds a valid instruction |
| id_pc | input | XLEN | PC of the instruction in ID |
| id_br_kind | input | 2 | Decoded branch kind of the ID instruction |
| id_imm | input | XLEN | Sign-extended offset of the ID instruction |
| id_rs_val | input | XLEN | Register operand read in ID |
| next_pc | output | XLEN | Fetch address for the next cycle |
| flush_ifid | output | 1 | Clear the IF/ID valid bit at the next edge |
| br_taken | output | 1 | Real outcome of the valid branch in ID |
| mispredict | output | 1 | ID branch outcome differs from its stored guess |

## Verification
Checked on every cycle:
- a non-branch or invalid ID slot never flushes or reports a taken outcome;
- a mispredict always comes with a flush and a redirect to the ID branch's own target or fall-through address;
- under the not-taken policy, only a taken branch can mispredict.

Shown only by the bench's scenarios:
- each policy's guess;
- the one-cycle penalty and its absence after a correct guess;
- ID-over-IF priority in `next_pc`;
- address wrap;
- the cleared guess after reset.

// File: rtl/ebu_pkg.sv
package ebu_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_EQZ  = 2'b01,
    BK_NEZ  = 2'b10,
    BK_RSVD = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    POL_NOT_TAKEN = 2'b00,
    POL_TAKEN     = 2'b01,
    POL_DIRECTION = 2'b10,
    POL_SPARE     = 2'b11
  } pred_policy_e;
endpackage

// File: rtl/ebu_pc_adder.sv
module ebu_pc_adder #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] tgt_pc
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  // Fall-through first, then target from it: R1
  always_comb begin
    seq_pc = pc + STEP_V;
    tgt_pc = seq_pc + imm;
  end
endmodule

// File: rtl/ebu_zero_test.sv
module ebu_zero_test
  import ebu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            valid,
  input  br_kind_e        kind,
  input  logic [XLEN-1:0] opnd,
  output logic            is_br,
  output logic            taken
);
  logic is_zero;

  always_comb begin
    is_zero = (opnd == '0);
    is_br   = 1'b0;
    taken   = 1'b0;
    if (valid) begin
      unique case (kind)
        BK_EQZ: begin is_br = 1'b1; taken = is_zero;  end
        BK_NEZ: begin is_br = 1'b1; taken = !is_zero; end
        default: begin is_br = 1'b0; taken = 1'b0;    end
      endcase
    end
  end

  // R2: no outcome without a real branch
  always_comb begin
    if (!is_br) a_r2_taken_needs_branch: assert (!taken);
  end
endmodule

// File: rtl/ebu_static_pred.sv
module ebu_static_pred
  import ebu_pkg::*;
(
  input  pred_policy_e policy,
  input  logic         fetch_br,
  input  logic         imm_neg,
  output logic         guess_taken
);
  always_comb begin
    guess_taken = 1'b0;
    if (fetch_br) begin
      unique case (policy)
        POL_TAKEN:     guess_taken = 1'b1;      // R4
        POL_DIRECTION: guess_taken = imm_neg;   // R5
        default:       guess_taken = 1'b0;      // R3
      endcase
    end
  end

  always_comb begin
    if (!fetch_br) a_r3_no_guess_without_branch: assert (!guess_taken);
  end
endmodule

// File: rtl/early_branch_unit.sv
module early_branch_unit
  import ebu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      policy,
  input  logic            if_valid,
  input  logic [XLEN-1:0] if_pc,
  input  logic            if_is_br,
  input  logic [XLEN-1:0] if_imm,
  input  logic            id_valid,
  input  logic [XLEN-1:0] id_pc,
  input  logic [1:0]      id_br_kind,
  input  logic [XLEN-1:0] id_imm,
  input  logic [XLEN-1:0] id_rs_val,
  output logic [XLEN-1:0] next_pc,
  output logic            flush_ifid,
  output logic            br_taken,
  output logic            mispredict
);
  localparam int SIGN = XLEN - 1;

  logic [XLEN-1:0] if_seq, if_tgt, id_seq, id_tgt;
  logic            fetch_br, guess, guess_q;
  logic            id_is_br, id_taken;

  // Fetch-side adder for predicted targets
  ebu_pc_adder #(.XLEN(XLEN), .STEP(STEP)) u_if_adder (
    .pc(if_pc), .imm(if_imm), .seq_pc(if_seq), .tgt_pc(if_tgt)
  );

  // Decode-side adder, independent of the ALU
  ebu_pc_adder #(.XLEN(XLEN), .STEP(STEP)) u_id_adder (
    .pc(id_pc), .imm(id_imm), .seq_pc(id_seq), .tgt_pc(id_tgt)
  );

  ebu_zero_test #(.XLEN(XLEN)) u_zero (
    .valid(id_valid), .kind(br_kind_e'(id_br_kind)), .opnd(id_rs_val),
    .is_br(id_is_br), .taken(id_taken)
  );

  assign fetch_br = if_valid && if_is_br;

  ebu_static_pred u_pred (
    .policy(pred_policy_e'(policy)), .fetch_br(fetch_br),
    .imm_neg(if_imm[SIGN]), .guess_taken(guess)
  );

  // Guess travels with the fetched word into IF/ID: R6, R10
  always_ff @(posedge clk) begin
    if (!rst_n) guess_q <= 1'b0;
    else        guess_q <= guess;
  end

  always_comb begin
    br_taken   = id_taken;
    mispredict = id_is_br && (id_taken != guess_q);
    flush_ifid = mispredict;
    if (mispredict)  next_pc = id_taken ? id_tgt : id_seq;   // R7
    else if (guess)  next_pc = if_tgt;                       // R4, R5
    else             next_pc = if_seq;                       // R3, R8
  end

  a_r9_idle_id_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid || id_br_kind == 2'b00 || id_br_kind == 2'b11)
      |-> (!flush_ifid && !mispredict && !br_taken));

  a_r7_mispredict_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> flush_ifid);

  a_r7_redirect_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> (next_pc == (br_taken ? id_pc + XLEN'(STEP) + id_imm
                                         : id_pc + XLEN'(STEP))));

  a_r6_nt_policy_only_taken_misses: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(policy == 2'b00) && mispredict) |-> br_taken);
endmodule

// File: tb/early_branch_unit_bench.sv
module early_branch_unit_bench;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      policy;
  logic            if_valid, if_is_br, id_valid;
  logic [XLEN-1:0] if_pc, if_imm, id_pc, id_imm, id_rs_val;
  logic [1:0]      id_br_kind;
  logic [XLEN-1:0] next_pc;
  logic            flush_ifid, br_taken, mispredict;

  int vectors = 0;
  int errs    = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  early_branch_unit #(.XLEN(XLEN), .STEP(4)) u_early_branch_unit (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .if_valid(if_valid), .if_pc(if_pc), .if_is_br(if_is_br), .if_imm(if_imm),
    .id_valid(id_valid), .id_pc(id_pc), .id_br_kind(id_br_kind),
    .id_imm(id_imm), .id_rs_val(id_rs_val),
    .next_pc(next_pc), .flush_ifid(flush_ifid),
    .br_taken(br_taken), .mispredict(mispredict)
  );

  task automatic chk(input string req, input string what,
                     input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic set_if(input logic v, input logic [XLEN-1:0] pc,
                        input logic br, input logic [XLEN-1:0] imm);
    if_valid = v; if_pc = pc; if_is_br = br; if_imm = imm;
  endtask

  task automatic set_id(input logic v, input logic [XLEN-1:0] pc, input logic [1:0] k,
                        input logic [XLEN-1:0] imm, input logic [XLEN-1:0] rs);
    id_valid = v; id_pc = pc; id_br_kind = k; id_imm = imm; id_rs_val = rs;
  endtask

  // Drive after the falling edge, sample 1 ns later, well before the rising edge
  task automatic next_slot();
    @(negedge clk);
  endtask

  function automatic bit model_guess(input logic [1:0] pol, input logic [XLEN-1:0] imm);
    if (pol == 2'b01) return 1'b1;
    if (pol == 2'b10) return imm[XLEN-1];
    return 1'b0;
  endfunction

  function automatic bit model_taken(input logic [1:0] k, input logic [XLEN-1:0] rs);
    if (k == 2'b01) return rs == 0;
    if (k == 2'b10) return rs != 0;
    return 1'b0;
  endfunction

  // Fetch a branch, then see it in ID the next cycle, then one quiet cycle
  task automatic branch_pair(input string req, input logic [1:0] pol,
                             input logic [XLEN-1:0] pc, input logic [XLEN-1:0] imm,
                             input logic [1:0] k, input logic [XLEN-1:0] rs);
    bit g, t;
    logic [XLEN-1:0] fetched;
    g = model_guess(pol, imm);
    t = model_taken(k, rs);
    fetched = g ? pc + 4 + imm : pc + 4;
    next_slot();
    policy = pol;
    set_if(1'b1, pc, 1'b1, imm);
    set_id(1'b0, 32'h0, 2'b00, 32'h0, 32'h0);
    #1;
    chk(req, "predicted fetch", next_pc, fetched);
    next_slot();
    set_if(1'b1, fetched, 1'b0, 32'h0);
    set_id(1'b1, pc, k, imm, rs);
    #1;
    chk("R2", "outcome", {31'b0, br_taken}, {31'b0, t});
    chk("R6", "mispredict", {31'b0, mispredict}, {31'b0, t != g});
    chk(t != g ? "R7" : "R8", "flush", {31'b0, flush_ifid}, {31'b0, t != g});
    chk(t != g ? "R7" : "R8", "next pc", next_pc,
        (t != g) ? (t ? pc + 4 + imm : pc + 4) : fetched + 4);
    next_slot();
    set_if(1'b1, fetched + 4, 1'b0, 32'h0);
    set_id(1'b0, fetched, 2'b00, 32'h0, 32'h0);
    #1;
    chk("R7", "one-cycle penalty", {31'b0, flush_ifid}, 32'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    policy = 2'b01;
    set_if(1'b1, 32'h100, 1'b1, 32'h40);   // a taken guess would be stored if not reset
    set_id(1'b0, 32'h0, 2'b00, 32'h0, 32'h0);
    repeat (3) @(posedge clk);
    next_slot();
    rst_n = 1'b1;
    set_if(1'b1, 32'h100, 1'b0, 32'h0);
    set_id(1'b1, 32'h0FC, 2'b01, 32'h20, 32'h0);   // taken: guess was cleared
    #1;
    chk("R10", "first branch mispredicts", {31'b0, mispredict}, 32'h1);
    chk("R10", "redirect", next_pc, 32'h0FC + 4 + 32'h20);
    next_slot();
    set_id(1'b0, 32'h0, 2'b00, 32'h0, 32'h0);
    #1;
    chk("R10", "idle flush", {31'b0, flush_ifid}, 32'h0);
    chk("R1", "idle next pc", next_pc, 32'h104);
  endtask

  task automatic t_not_taken();
    branch_pair("R3", 2'b00, 32'h200, 32'h10, 2'b01, 32'h0);   // taken: penalty
    branch_pair("R3", 2'b00, 32'h300, 32'h10, 2'b10, 32'h0);   // not taken
    branch_pair("R3", 2'b11, 32'h400, 32'hFFFF_FFF0, 2'b10, 32'h9);   // spare policy
  endtask

  task automatic t_taken();
    branch_pair("R4", 2'b01, 32'h500, 32'hFFFF_FFF8, 2'b01, 32'h5);   // not taken: miss
    branch_pair("R4", 2'b01, 32'h600, 32'h40, 2'b10, 32'h7);          // taken: hit
  endtask

  task automatic t_direction();
    branch_pair("R5", 2'b10, 32'h700, 32'hFFFF_FFE0, 2'b01, 32'h0);   // back, taken
    branch_pair("R5", 2'b10, 32'h800, 32'h0C, 2'b10, 32'h3);          // fwd, taken: miss
    branch_pair("R5", 2'b10, 32'h900, 32'h0C, 2'b01, 32'h3);          // fwd, not taken
    branch_pair("R5", 2'b10, 32'hA00, 32'hFFFF_FF00, 2'b10, 32'h0);   // back, not taken: miss
  endtask

  task automatic t_ignore();
    // stored taken guess, then invalid branch-kind slot in ID
    next_slot();
    policy = 2'b01;
    set_if(1'b1, 32'hB00, 1'b1, 32'h80);
    set_id(1'b0, 32'h0, 2'b00, 32'h0, 32'h0);
    next_slot();
    set_if(1'b1, 32'hB84, 1'b0, 32'h0);
    set_id(1'b0, 32'hB00, 2'b01, 32'h80, 32'h0);
    #1;
    chk("R9", "invalid slot flush", {31'b0, flush_ifid}, 32'h0);
    chk("R9", "invalid slot taken", {31'b0, br_taken}, 32'h0);
    chk("R9", "invalid slot next", next_pc, 32'hB88);
    // stored taken guess, then valid non-branch kinds in ID
    next_slot();
    set_if(1'b1, 32'hC00, 1'b1, 32'h80);
    set_id(1'b0, 32'h0, 2'b00, 32'h0, 32'h0);
    next_slot();
    set_if(1'b1, 32'hC84, 1'b0, 32'h0);
    set_id(1'b1, 32'hC00, 2'b11, 32'h80, 32'h0);
    #1;
    chk("R9", "kind 11 flush", {31'b0, flush_ifid}, 32'h0);
    chk("R9", "kind 11 mispredict", {31'b0, mispredict}, 32'h0);
    next_slot();
    set_if(1'b1, 32'hC88, 1'b0, 32'h0);
    set_id(1'b1, 32'hC84, 2'b00, 32'h0, 32'h0);
    #1;
    chk("R9", "kind 00 flush", {31'b0, flush_ifid}, 32'h0);
    chk("R9", "kind 00 next", next_pc, 32'hC8C);
  endtask

  task automatic t_priority();
    // ID misses while IF has a branch guessed taken: ID redirect wins
    next_slot();
    policy = 2'b00;
    set_if(1'b1, 32'hD00, 1'b1, 32'h20);
    set_id(1'b0, 32'h0, 2'b00, 32'h0, 32'h0);
    next_slot();
    policy = 2'b01;
    set_if(1'b1, 32'hD04, 1'b1, 32'h100);
    set_id(1'b1, 32'hD00, 2'b01, 32'h20, 32'h0);
    #1;
    chk("R7", "redirect over IF guess", next_pc, 32'hD24);
    chk("R7", "flush with IF guess", {31'b0, flush_ifid}, 32'h1);
  endtask

  task automatic t_wrap();
    next_slot();
    policy = 2'b01;
    set_if(1'b1, 32'hFFFF_FFFC, 1'b1, 32'h8);
    set_id(1'b0, 32'h0, 2'b00, 32'h0, 32'h0);
    #1;
    chk("R1", "IF target wraps", next_pc, 32'h8);
    next_slot();
    policy = 2'b00;
    set_if(1'b1, 32'hFFFF_FFFC, 1'b0, 32'h0);
    set_id(1'b1, 32'hFFFF_FFF8, 2'b10, 32'h0, 32'h1);   // guess taken, real taken
    #1;
    chk("R1", "IF sequential wraps", next_pc, 32'h0);
    next_slot();
    set_if(1'b1, 32'h0, 1'b0, 32'h0);
    set_id(1'b1, 32'hFFFF_FFFC, 2'b01, 32'h10, 32'h0);   // no guess stored, taken
    #1;
    chk("R1", "ID target wraps", next_pc, 32'h10);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_not_taken();
    t_taken();
    t_direction();
    t_ignore();
    t_priority();
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule